// File: doc/BRIEF.md
# Multi-Event Hit Buffer with Fast-Clear Window

This block collects tagged hit words from a time digitizer and stores each event in one fixed slot of a circular buffer. A word whose bit 23 is 1 says that more words of the same event follow, and a word whose bit 23 is 0 closes the event. Once the closing word arrives, a programmable fast-clear window opens. If an external fast-clear pulse arrives during filling or during the window, the event is dropped and its slot is reused. If the window runs out with no clear, the event is committed and becomes visible to readout.

Readout addresses a slot and a word within it. Committed events are read oldest first, and reading the closing word of the oldest event frees its slot. A 5-bit count reports how many committed events are waiting. A busy output tells the front end when words cannot be taken.

Top module: `hit_event_buffer`

## Requirements
- R1: After reset, `evt_pending` is 0 and `rd_data` is 0. With `acq_en` high, `busy` is 0.
- R2: Words of an event are stored in arrival order from word 0 of the slot after the last committed one. The first word whose bit 23 is 0 ends the event.
- R3: The window is `win_cfg` × `TICKS_PER_US` clock cycles long, where `win_cfg` = 0 means 128 steps. The count is sampled when the closing word is taken. `evt_pending` rises by one exactly that many cycles after the edge that took the closing word.
- R4: A `fclr` pulse of one cycle, sampled while an event is filling or inside its window, discards that event. The block is idle after the next edge, `evt_pending` is unchanged, and the next event lands in the same slot.
- R5: `fclr` sampled while no event is in progress changes nothing: committed events and the count remain as they were.
- R6: `busy` is 1 while an event is filling or in its window, while `acq_en` is 0, and while all `SLOTS` slots hold committed events.
- R7: A word offered while `busy` is 1 and no event is filling is ignored. This covers words offered during the window, while disabled and while full.
- R8: Words past `SLOT_WORDS` in an event are dropped. The word stored at index `SLOT_WORDS`−1 has bit 23 forced to 0. The event still ends at its real closing word.
- R9: `rd_data` shows the addressed word one cycle after `rd_en`. It reads 0 if the slot does not hold a committed event, and it holds its value when `rd_en` is low.
- R10: Reading the closing word of the oldest committed event frees its slot and lowers `evt_pending` by one. Reading any other word, or any other slot, frees nothing.
- R11: `evt_pending` is the low 5 bits of the count, so with 32 committed events it reads 0 while `busy` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_en | input | 1 | Acquisition enable; low blocks new events |
| win_cfg | input | 7 | Fast-clear window in 1 µs steps, 0 = 128 |
| hit_vld | input | 1 | Hit word strobe |
| hit_word | input | 24 | Hit word; bit 23 = 1 means more follow |
| fclr | input | 1 | Fast-clear request |
| rd_en | input | 1 | Read strobe |
| rd_slot | input | 5 | Slot to read |
| rd_word | input | 6 | Word index within the slot |
| rd_data | output | 24 | Registered read data |
| evt_pending | output | 5 | Committed events waiting (mod 32) |
| busy | output | 1 | Front end cannot accept a new event |

## Verification
The bench attacks the boundary of the window from both sides. A commit one cycle early or late, or a clear that loses against expiry, shows up as a pending-count mismatch. Clears during filling, during the window and while idle make sure a discard neither advances the slot pointer nor disturbs events already committed. An overlong event checks that the forced end marker lands on the last stored word and that freeing keys on that word. Filling all 32 slots checks the 5-bit wrap of the count and confirms that words offered while full or disabled never start an event.

// File: rtl/heb_pkg.sv
package heb_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_FILL = 2'd1,
        CAP_WIN  = 2'd2
    } cap_state_e;
endpackage

// File: rtl/heb_window.sv
module heb_window #(
    parameter int TICKS_PER_US = 50,
    parameter int CFG_W        = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CFG_W-1:0] cfg,
    input  logic             abort,
    output logic             expire
);
    localparam int STEPS = 1 << CFG_W;
    localparam int MAXT  = STEPS * TICKS_PER_US;
    localparam int TW    = $clog2(MAXT);

    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } win_t;

    win_t win_d, win_q;
    int unsigned steps;

    assign expire = win_q.run && (win_q.cnt == '0);

    always_comb begin
        win_d = win_q;
        steps = (cfg == '0) ? STEPS : 32'(cfg);
        if (start) begin
            win_d.run = 1'b1;
            win_d.cnt = TW'(steps * TICKS_PER_US - 1);
        end else if (abort || expire) begin
            win_d.run = 1'b0;
        end else if (win_q.run) begin
            win_d.cnt = win_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end
endmodule

// File: rtl/heb_ring.sv
module heb_ring #(
    parameter int SLOTS = 32,
    parameter int WORDS = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [$clog2(WORDS)-1:0] commit_last,
    input  logic                     rd_en,
    input  logic [$clog2(SLOTS)-1:0] rd_slot,
    input  logic [$clog2(WORDS)-1:0] rd_word,
    output logic [$clog2(SLOTS)-1:0] head,
    output logic [$clog2(SLOTS)-1:0] count,
    output logic                     full,
    output logic                     rd_ok,
    output logic                     freed
);
    localparam int SW = $clog2(SLOTS);
    localparam int AW = $clog2(WORDS);

    typedef struct packed {
        logic [SW-1:0]             head;
        logic [SW-1:0]             tail;
        logic [SW:0]               cnt;
        logic [SLOTS-1:0][AW-1:0]  last;
    } ring_t;

    ring_t ring_d, ring_q;
    logic [SW-1:0] off;

    assign off   = rd_slot - ring_q.tail;
    assign rd_ok = ({1'b0, off} < ring_q.cnt);
    assign freed = rd_en && rd_ok && (off == '0) &&
                   (rd_word == ring_q.last[ring_q.tail]);
    assign head  = ring_q.head;
    assign count = ring_q.cnt[SW-1:0];
    assign full  = ring_q.cnt[SW];

    always_comb begin
        ring_d = ring_q;
        if (commit) begin
            ring_d.last[ring_q.head] = commit_last;
            ring_d.head = ring_q.head + 1'b1;
        end
        if (freed) begin
            ring_d.tail = ring_q.tail + 1'b1;
        end
        case ({commit, freed})
            2'b10:   ring_d.cnt = ring_q.cnt + 1'b1;
            2'b01:   ring_d.cnt = ring_q.cnt - 1'b1;
            default: ring_d.cnt = ring_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end
endmodule

// File: rtl/heb_store.sv
module heb_store #(
    parameter int SLOTS  = 32,
    parameter int WORDS  = 64,
    parameter int WORD_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(SLOTS)-1:0] wslot,
    input  logic [$clog2(WORDS)-1:0] wword,
    input  logic [WORD_W-1:0]        wdata,
    input  logic                     re,
    input  logic [$clog2(SLOTS)-1:0] rslot,
    input  logic [$clog2(WORDS)-1:0] rword,
    input  logic                     rok,
    output logic [WORD_W-1:0]        rdata
);
    localparam int DEPTH = SLOTS * WORDS;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[{wslot, wword}] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = rok ? mem[{rslot, rword}] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/hit_event_buffer.sv
module hit_event_buffer #(
    parameter int SLOTS        = 32,
    parameter int SLOT_WORDS   = 64,
    parameter int WORD_W       = 24,
    parameter int TICKS_PER_US = 50,
    parameter int CFG_W        = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acq_en,
    input  logic [CFG_W-1:0]              win_cfg,
    input  logic                          hit_vld,
    input  logic [WORD_W-1:0]             hit_word,
    input  logic                          fclr,
    input  logic                          rd_en,
    input  logic [$clog2(SLOTS)-1:0]      rd_slot,
    input  logic [$clog2(SLOT_WORDS)-1:0] rd_word,
    output logic [WORD_W-1:0]             rd_data,
    output logic [$clog2(SLOTS)-1:0]      evt_pending,
    output logic                          busy
);
    import heb_pkg::*;

    localparam int SW  = $clog2(SLOTS);
    localparam int AW  = $clog2(SLOT_WORDS);
    localparam int END = WORD_W - 1;

    typedef struct packed {
        cap_state_e    st;
        logic [AW:0]   wcnt;
        logic [AW-1:0] last;
    } cap_t;

    cap_t cap_d, cap_q;

    logic              take, room, st_we;
    logic [AW:0]       idx;
    logic [AW-1:0]     st_wword;
    logic [WORD_W-1:0] st_wdata;
    logic              win_start, win_abort, win_expire;
    logic              commit, freed, full, rd_ok, cap_idle;
    logic [SW-1:0]     head;

    assign cap_idle = (cap_q.st == CAP_IDLE);

    always_comb begin
        cap_d     = cap_q;
        take      = 1'b0;
        win_start = 1'b0;
        win_abort = 1'b0;
        commit    = 1'b0;
        idx       = cap_idle ? '0 : cap_q.wcnt;
        room      = idx < (AW+1)'(SLOT_WORDS);
        st_wword  = idx[AW-1:0];
        st_wdata  = hit_word;
        if (idx == (AW+1)'(SLOT_WORDS - 1)) st_wdata[END] = 1'b0;

        case (cap_q.st)
            CAP_IDLE: take = hit_vld && acq_en && !full;
            CAP_FILL: begin
                if (fclr) begin
                    cap_d.st   = CAP_IDLE;
                    cap_d.wcnt = '0;
                end else begin
                    take = hit_vld;
                end
            end
            CAP_WIN: begin
                if (fclr) begin
                    win_abort  = 1'b1;
                    cap_d.st   = CAP_IDLE;
                    cap_d.wcnt = '0;
                end else if (win_expire) begin
                    commit     = 1'b1;
                    cap_d.st   = CAP_IDLE;
                    cap_d.wcnt = '0;
                end
            end
            default: cap_d.st = CAP_IDLE;
        endcase

        st_we = take && room;
        if (take) begin
            if (room) begin
                cap_d.last = idx[AW-1:0];
                cap_d.wcnt = idx + 1'b1;
            end else begin
                cap_d.wcnt = idx;
            end
            if (!hit_word[END]) begin
                cap_d.st  = CAP_WIN;
                win_start = 1'b1;
            end else begin
                cap_d.st  = CAP_FILL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '{st: CAP_IDLE, wcnt: '0, last: '0};
        else        cap_q <= cap_d;
    end

    heb_window #(.TICKS_PER_US(TICKS_PER_US), .CFG_W(CFG_W)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (win_start),
        .cfg    (win_cfg),
        .abort  (win_abort),
        .expire (win_expire)
    );

    heb_ring #(.SLOTS(SLOTS), .WORDS(SLOT_WORDS)) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_last (cap_q.last),
        .rd_en       (rd_en),
        .rd_slot     (rd_slot),
        .rd_word     (rd_word),
        .head        (head),
        .count       (evt_pending),
        .full        (full),
        .rd_ok       (rd_ok),
        .freed       (freed)
    );

    heb_store #(.SLOTS(SLOTS), .WORDS(SLOT_WORDS), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .wslot (head),
        .wword (st_wword),
        .wdata (st_wdata),
        .re    (rd_en),
        .rslot (rd_slot),
        .rword (rd_word),
        .rok   (rd_ok),
        .rdata (rd_data)
    );

    assign busy = !cap_idle || !acq_en || full;
endmodule

// File: rtl/heb_checker.sv
module heb_checker #(
    parameter int SLOTS  = 32,
    parameter int WORDS  = 64,
    parameter int WORD_W = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     fclr,
    input logic                     rd_en,
    input logic [WORD_W-1:0]        rd_data,
    input logic [$clog2(SLOTS)-1:0] evt_pending,
    input logic                     cap_idle,
    input logic                     we,
    input logic [$clog2(WORDS)-1:0] wword,
    input logic                     wend,
    input logic                     full,
    input logic                     rd_ok,
    input logic                     commit,
    input logic                     freed
);
    // pending count moves only after a commit or a free
    assert_pending_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pending != $past(evt_pending)) |-> ($past(commit) || $past(freed)));

    assert_clear_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fclr && !cap_idle) |=> cap_idle);

    assert_forced_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wword == $clog2(WORDS)'(WORDS - 1))) |-> !wend);

    assert_full_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !we);

    assert_unready_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_ok) |=> (rd_data == '0));
endmodule

bind hit_event_buffer heb_checker #(
    .SLOTS(SLOTS), .WORDS(SLOT_WORDS), .WORD_W(WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fclr        (fclr),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .evt_pending (evt_pending),
    .cap_idle    (cap_idle),
    .we          (st_we),
    .wword       (st_wword),
    .wend        (st_wdata[WORD_W-1]),
    .full        (full),
    .rd_ok       (rd_ok),
    .commit      (commit),
    .freed       (freed)
);

// File: tb/hit_event_buffer_test.sv
module hit_event_buffer_test;
    localparam int S  = 32;
    localparam int WD = 64;
    localparam int TK = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acq_en = 1'b1;
    logic [6:0]  win_cfg = 7'd1;
    logic        hit_vld = 1'b0;
    logic [23:0] hit_word = '0;
    logic        fclr = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_slot = '0;
    logic [5:0]  rd_word = '0;
    logic [23:0] rd_data;
    logic [4:0]  evt_pending;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    hit_event_buffer uut (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .win_cfg(win_cfg),
        .hit_vld(hit_vld), .hit_word(hit_word), .fclr(fclr),
        .rd_en(rd_en), .rd_slot(rd_slot), .rd_word(rd_word),
        .rd_data(rd_data), .evt_pending(evt_pending), .busy(busy)
    );

    // behavioural reference
    int          m_st, m_wcnt, m_tmr, m_head, m_tail, m_pend, m_lidx;
    int          m_last [S];
    logic [23:0] m_mem [S][WD];
    logic [23:0] m_rd;
    int          m_off, m_idx;
    bit          m_ok, m_fr, m_cm, m_take;
    logic [23:0] m_w;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_wcnt = 0; m_tmr = 0; m_head = 0; m_tail = 0;
            m_pend = 0; m_lidx = 0; m_rd = '0;
            for (int i = 0; i < S; i++) m_last[i] = 0;
        end else begin
            m_fr = 0; m_cm = 0; m_take = 0;
            if (rd_en) begin
                m_off = (int'(rd_slot) - m_tail + S) % S;
                m_ok  = m_off < m_pend;
                m_rd  = m_ok ? m_mem[rd_slot][rd_word] : 24'h0;
                m_fr  = m_ok && (m_off == 0) && (int'(rd_word) == m_last[m_tail]);
            end
            if (m_st == 0) m_take = hit_vld && acq_en && (m_pend != S);
            else if (m_st == 1) begin
                if (fclr) m_st = 0; else m_take = hit_vld;
            end else begin
                if (fclr) m_st = 0;
                else if (m_tmr == 0) begin m_cm = 1; m_st = 0; end
                else m_tmr--;
            end
            if (m_take) begin
                m_idx = (m_st == 0) ? 0 : m_wcnt;
                if (m_idx < WD) begin
                    m_w = hit_word;
                    if (m_idx == WD - 1) m_w[23] = 1'b0;
                    m_mem[m_head][m_idx] = m_w;
                    m_lidx = m_idx;
                end
                m_wcnt = m_idx + 1;
                if (!hit_word[23]) begin
                    m_st = 2;
                    m_tmr = ((win_cfg == 0) ? 128 : int'(win_cfg)) * TK - 1;
                end else m_st = 1;
            end
            if (m_cm) begin
                m_last[m_head] = m_lidx;
                m_head = (m_head + 1) % S;
                m_pend++;
            end
            if (m_fr) begin
                m_tail = (m_tail + 1) % S;
                m_pend--;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, offset from the falling edge so inputs have settled
    always begin
        @(negedge clk);
        #4;
        if (rst_n) begin
            chk(busy == ((m_st != 0) || !acq_en || (m_pend == S)), "R6 busy", busy,
                (m_st != 0) || !acq_en || (m_pend == S));
            chk(evt_pending == 5'(m_pend % S), "R3 pending", evt_pending, m_pend % S);
            chk(rd_data == m_rd, "R9 rd_data", rd_data, m_rd);
        end
    end

    task automatic put(input logic [23:0] w);
        hit_vld = 1'b1; hit_word = w;
        @(negedge clk);
        hit_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input int slot, input int word);
        rd_en = 1'b1; rd_slot = 5'(slot); rd_word = 6'(word);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_clear;
        fclr = 1'b1;
        @(negedge clk);
        fclr = 1'b0;
    endtask

    task automatic wait_change(output int n);
        logic [4:0] p0;
        p0 = evt_pending;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (evt_pending == p0 && n < 10000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R3 watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        idle(5);
        rst_n = 1'b1;
        idle(1);
        chk(evt_pending == 0, "R1 pending after reset", evt_pending, 0);
        chk(rd_data == 0, "R1 rd_data after reset", rd_data, 0);
        chk(busy == 0, "R1 busy after reset", busy, 0);

        // basic event into slot 0
        put(24'h800101); put(24'h800102); put(24'h000103);
        chk(busy == 1, "R6 busy in window", busy, 1);
        wait_change(n);
        chk(n == TK, "R3 window 1us", n, TK);
        chk(evt_pending == 1, "R3 committed", evt_pending, 1);
        rd(0, 0);
        chk(rd_data == 24'h800101, "R2 word0", rd_data, 24'h800101);
        chk(evt_pending == 1, "R10 no free on word0", evt_pending, 1);
        rd(0, 1);
        chk(rd_data == 24'h800102, "R2 word1", rd_data, 24'h800102);
        rd(1, 0);
        chk(rd_data == 0, "R9 uncommitted slot", rd_data, 0);
        rd(0, 2);
        chk(rd_data == 24'h000103, "R9 closing word", rd_data, 24'h000103);
        chk(evt_pending == 0, "R10 freed", evt_pending, 0);

        // clear while filling
        put(24'h800201); put(24'h800202);
        pulse_clear();
        chk(busy == 0, "R4 idle after fill clear", busy, 0);
        put(24'h000301);
        wait_change(n);
        chk(evt_pending == 1, "R4 next event commits", evt_pending, 1);
        rd(1, 0);
        chk(rd_data == 24'h000301, "R4 slot reused", rd_data, 24'h000301);

        // clear inside window
        put(24'h000401);
        idle(10);
        pulse_clear();
        chk(busy == 0, "R4 idle after window clear", busy, 0);
        idle(60);
        chk(evt_pending == 0, "R4 discarded", evt_pending, 0);
        put(24'h000402);
        wait_change(n);
        rd(2, 0);
        chk(rd_data == 24'h000402, "R4 slot 2 reused", rd_data, 24'h000402);

        // clear while idle
        put(24'h800501); put(24'h000502);
        wait_change(n);
        chk(n == TK, "R5 window", n, TK);
        pulse_clear();
        idle(3);
        chk(evt_pending == 1, "R5 clear ignored", evt_pending, 1);
        rd(3, 1);
        chk(rd_data == 24'h000502, "R5 data intact", rd_data, 24'h000502);

        // longest window
        win_cfg = 7'd0;
        put(24'h000601);
        wait_change(n);
        chk(n == 128 * TK, "R3 window 128us", n, 128 * TK);
        rd(4, 0);
        win_cfg = 7'd1;

        // disabled and in-window words ignored
        acq_en = 1'b0;
        idle(1);
        chk(busy == 1, "R6 busy disabled", busy, 1);
        put(24'h000701);
        idle(60);
        chk(evt_pending == 0, "R7 disabled ignored", evt_pending, 0);
        acq_en = 1'b1;
        put(24'h000702);
        wait_change(n);
        rd(5, 0);
        chk(rd_data == 24'h000702, "R7 slot 5", rd_data, 24'h000702);
        put(24'h000801);
        put(24'h000802);
        wait_change(n);
        idle(60);
        chk(evt_pending == 1, "R7 window word ignored", evt_pending, 1);
        rd(6, 0);
        chk(rd_data == 24'h000801, "R7 slot 6", rd_data, 24'h000801);
        rd(7, 0);
        chk(rd_data == 0, "R7 slot 7 empty", rd_data, 0);

        // overlong event
        for (int k = 0; k < 70; k++) put({(k != 69), 23'(k)});
        wait_change(n);
        rd(7, 62);
        chk(rd_data == 24'h80003E, "R8 word 62", rd_data, 24'h80003E);
        chk(evt_pending == 1, "R10 word 62 keeps", evt_pending, 1);
        rd(7, 63);
        chk(rd_data == 24'h00003F, "R8 forced end", rd_data, 24'h00003F);
        chk(evt_pending == 0, "R8 free at last stored", evt_pending, 0);

        // fill every slot
        for (int e = 0; e < S; e++) begin
            put(24'h00A000 | 24'(e));
            idle(TK + 2);
        end
        chk(evt_pending == 0, "R11 count wraps", evt_pending, 0);
        chk(busy == 1, "R6 busy full", busy, 1);
        put(24'h000B00);
        idle(60);
        rd(8, 0);
        chk(rd_data == 24'h00A000, "R9 oldest", rd_data, 24'h00A000);
        chk(evt_pending == 31, "R11 after free", evt_pending, 31);
        chk(busy == 0, "R6 not full", busy, 0);
        idle(60);
        chk(evt_pending == 31, "R7 full word ignored", evt_pending, 31);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule